// File: doc/BRIEF.md
# Private-Cache Coherence Line Controller

This block is the protocol engine of one private first-level cache in a two-level, directory-based coherence system. It holds a small, fully associative set of lines. Each line has an address tag, a data word and one of four states: Nothing, Shared, Exclusive or Pending. Any line in Nothing is a free slot. Processor loads and stores are answered from the lines when the state allows it. Otherwise the controller sends a request to the home node and leaves the processor request waiting at the head of its queue, so the cache is blocking.

Requests from the home node are served in one cycle. A request for a line the cache does not hold is consumed with no reply. These requests are invalidate, writeback and flush. Replies from the home node that grant data are also served in one cycle. An explicit eviction input gives a line up on purpose. It either releases the line entirely or writes it back and keeps a shared copy. Each cycle the controller serves one source, in a fixed order: home message first, then eviction, then processor. It emits at most one outgoing message per cycle.

Top module: `coh_l1_ctrl`

## Requirements
- R1: After reset, `out_valid`, `resp_valid` and `proc_deq` are 0 and every line is in Nothing, so the first access to any address misses.
- R2: A load to a line in Shared or Exclusive asserts `proc_deq` in the same cycle. In the next cycle it gives `resp_valid` with `resp_is_ack`=0 and the line's data.
- R3: A load to a line in Nothing does not dequeue. It sends SHREQ (`out_cmd`=0) for that address and moves the line to Pending. A processor request to a Pending line does not dequeue and sends nothing.
- R4: A store to an Exclusive line writes `proc_wdata` and dequeues. In the next cycle it gives `resp_valid` with `resp_is_ack`=1.
- R5: A store to a line in Nothing sends EXREQ (`out_cmd`=1) and moves the line to Pending. A store to a Shared line sends INVREP (`out_cmd`=2) and moves the line to Nothing. Neither store dequeues.
- R6: A home SHREP (`home_cmd`=0) sets the line to Shared with `home_data`. A home EXREP (`home_cmd`=1) sets the line to Exclusive with `home_data`. Neither sends a message.
- R7: A home INVREQ (`home_cmd`=2) on a Shared line sends INVREP and moves the line to Nothing. In any other state it is dropped with no reply and no state change.
- R8: A home WBREQ (`home_cmd`=3) on an Exclusive line sends WBREP (`out_cmd`=3) with the line data and moves the line to Shared. In any other state it is dropped.
- R9: A home FLUSHREQ (`home_cmd`=4) on an Exclusive line sends FLUSHREP (`out_cmd`=4) with the data and moves the line to Nothing. On a Shared line it sends INVREP and moves the line to Nothing. On Nothing or Pending it is dropped.
- R10: An eviction with `evict_keep`=0 sends INVREP from Shared or FLUSHREP with data from Exclusive, and the line goes to Nothing. An eviction with `evict_keep`=1 sends WBREP with data from Exclusive and leaves the line Shared. Every other eviction has no effect.
- R11: `home_deq` equals `home_valid`. A home message blocks eviction and processor service in that cycle, and an eviction blocks processor service.
- R12: When a miss needs a new line and no line is in Nothing, the request stalls with no message. At most one line holds a given address.
- R13: Outgoing messages appear one cycle after the decision as single-cycle `out_valid` pulses. SHREQ, EXREQ and INVREP carry `out_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_valid | input | 1 | Processor request present at queue head |
| proc_is_store | input | 1 | 1 = store, 0 = load |
| proc_addr | input | AW | Request address |
| proc_wdata | input | DW | Store data |
| proc_deq | output | 1 | Processor request consumed this cycle |
| resp_valid | output | 1 | Processor response pulse |
| resp_is_ack | output | 1 | 1 = store ack, 0 = load data |
| resp_data | output | DW | Load data (0 for acks) |
| home_valid | input | 1 | Home message present |
| home_cmd | input | 3 | 0 SHREP, 1 EXREP, 2 INVREQ, 3 WBREQ, 4 FLUSHREQ |
| home_addr | input | AW | Home message address |
| home_data | input | DW | Data carried by SHREP/EXREP |
| home_deq | output | 1 | Home message consumed |
| evict_valid | input | 1 | Voluntary eviction request |
| evict_keep | input | 1 | 1 = writeback keeping Shared, 0 = release |
| evict_addr | input | AW | Eviction address |
| evict_deq | output | 1 | Eviction request consumed |
| out_valid | output | 1 | Outgoing message pulse to home |
| out_cmd | output | 3 | 0 SHREQ, 1 EXREQ, 2 INVREP, 3 WBREP, 4 FLUSHREP |
| out_addr | output | AW | Outgoing message address |
| out_data | output | DW | Outgoing data (0 when none) |

## Verification
A corrupted line state has no output of its own. It shows up at the next access to that line: a hit that should have been a miss returns data instead of sending SHREQ, or a writeback or flush request is wrongly dropped or wrongly answered. Stale data shows up on the following load response, one cycle after `proc_deq`. The bench therefore follows every state-changing event with a probe through the processor, home or eviction inputs. That probe exposes the state within two cycles.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_NOTHING = 2'd0,
    LN_SH      = 2'd1,
    LN_EX      = 2'd2,
    LN_PEND    = 2'd3
  } line_st_e;

  localparam logic [2:0] HM_SHREP  = 3'd0;
  localparam logic [2:0] HM_EXREP  = 3'd1;
  localparam logic [2:0] HM_INVREQ = 3'd2;
  localparam logic [2:0] HM_WBREQ  = 3'd3;
  localparam logic [2:0] HM_FLREQ  = 3'd4;

  typedef enum logic [2:0] {
    OM_SHREQ  = 3'd0,
    OM_EXREQ  = 3'd1,
    OM_INVREP = 3'd2,
    OM_WBREP  = 3'd3,
    OM_FLREP  = 3'd4
  } out_cmd_e;

  typedef struct packed {
    logic     send;
    out_cmd_e cmd;
    logic     line_data;
    logic     set_st;
    line_st_e nst;
    logic     take_home;
    logic     take_store;
    logic     deq;
  } act_t;

  // Reaction to a message from home, given the current line state.
  function automatic act_t home_action(input logic [2:0] c, input line_st_e s);
    act_t a;
    a = '0;
    case (c)
      HM_SHREP: begin a.set_st = 1'b1; a.nst = LN_SH; a.take_home = 1'b1; end
      HM_EXREP: begin a.set_st = 1'b1; a.nst = LN_EX; a.take_home = 1'b1; end
      HM_INVREQ:
        if (s == LN_SH) begin
          a.send = 1'b1; a.cmd = OM_INVREP; a.set_st = 1'b1; a.nst = LN_NOTHING;
        end
      HM_WBREQ:
        if (s == LN_EX) begin
          a.send = 1'b1; a.cmd = OM_WBREP; a.line_data = 1'b1;
          a.set_st = 1'b1; a.nst = LN_SH;
        end
      HM_FLREQ:
        if (s == LN_EX) begin
          a.send = 1'b1; a.cmd = OM_FLREP; a.line_data = 1'b1;
          a.set_st = 1'b1; a.nst = LN_NOTHING;
        end else if (s == LN_SH) begin
          a.send = 1'b1; a.cmd = OM_INVREP; a.set_st = 1'b1; a.nst = LN_NOTHING;
        end
      default: a = '0;
    endcase
    return a;
  endfunction

  // Voluntary give-up: keep=1 writes back and stays shared, keep=0 releases.
  function automatic act_t evict_action(input logic keep, input line_st_e s);
    act_t a;
    a = '0;
    if (keep) begin
      if (s == LN_EX) begin
        a.send = 1'b1; a.cmd = OM_WBREP; a.line_data = 1'b1;
        a.set_st = 1'b1; a.nst = LN_SH;
      end
    end else if (s == LN_EX) begin
      a.send = 1'b1; a.cmd = OM_FLREP; a.line_data = 1'b1;
      a.set_st = 1'b1; a.nst = LN_NOTHING;
    end else if (s == LN_SH) begin
      a.send = 1'b1; a.cmd = OM_INVREP; a.set_st = 1'b1; a.nst = LN_NOTHING;
    end
    return a;
  endfunction

  // Processor request handling; only hits dequeue.
  function automatic act_t proc_action(input logic st, input line_st_e s);
    act_t a;
    a = '0;
    case (s)
      LN_SH:
        if (st) begin
          a.send = 1'b1; a.cmd = OM_INVREP; a.set_st = 1'b1; a.nst = LN_NOTHING;
        end else a.deq = 1'b1;
      LN_EX: begin
        a.deq = 1'b1;
        if (st) begin a.set_st = 1'b1; a.nst = LN_EX; a.take_store = 1'b1; end
      end
      LN_NOTHING: begin
        a.send = 1'b1; a.cmd = st ? OM_EXREQ : OM_SHREQ;
        a.set_st = 1'b1; a.nst = LN_PEND;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int AW     = 8,
  parameter int DW     = 16,
  localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output line_st_e      lk_st,
  output logic [DW-1:0] lk_data,
  output logic          free_ok,
  output logic [IW-1:0] free_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  line_st_e      wr_st,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_dat_en,
  input  logic [DW-1:0] wr_dat
);

  line_st_e      st_q  [NLINES];
  logic [AW-1:0] tag_q [NLINES];
  logic [DW-1:0] dat_q [NLINES];
  logic [NLINES-1:0] match, free;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign match[g] = (st_q[g] != LN_NOTHING) && (tag_q[g] == look_addr);
    assign free[g]  = (st_q[g] == LN_NOTHING);
  end

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0; free_ok = 1'b0; free_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (match[i]) begin lk_hit = 1'b1; lk_idx = IW'(i); end
      if (free[i]) begin free_ok = 1'b1; free_idx = IW'(i); end
    end
  end

  assign lk_st   = st_q[lk_idx];
  assign lk_data = dat_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i] <= LN_NOTHING; tag_q[i] <= '0; dat_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_st;
      tag_q[wr_idx] <= wr_addr;
      if (wr_dat_en) dat_q[wr_idx] <= wr_dat;
    end
  end

  // R12: allocation never duplicates an address among held lines
  p_unique_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/coh_l1_ctrl.sv
module coh_l1_ctrl
  import coh_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int AW     = 8,
  parameter int DW     = 16,
  localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proc_valid,
  input  logic          proc_is_store,
  input  logic [AW-1:0] proc_addr,
  input  logic [DW-1:0] proc_wdata,
  output logic          proc_deq,
  output logic          resp_valid,
  output logic          resp_is_ack,
  output logic [DW-1:0] resp_data,
  input  logic          home_valid,
  input  logic [2:0]    home_cmd,
  input  logic [AW-1:0] home_addr,
  input  logic [DW-1:0] home_data,
  output logic          home_deq,
  input  logic          evict_valid,
  input  logic          evict_keep,
  input  logic [AW-1:0] evict_addr,
  output logic          evict_deq,
  output logic          out_valid,
  output logic [2:0]    out_cmd,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  logic src_home, src_ev, src_proc;
  logic [AW-1:0] sel_addr;
  logic          lk_hit, free_ok;
  logic [IW-1:0] lk_idx, free_idx;
  line_st_e      lk_st, cur_st;
  logic [DW-1:0] lk_data;
  act_t          act;
  logic          need_alloc, go, ev_msg, ev_resp;

  // Source arbitration: home, then eviction, then processor.
  assign src_home = home_valid;
  assign src_ev   = evict_valid && !home_valid;
  assign src_proc = proc_valid && !home_valid && !evict_valid;
  assign sel_addr = src_home ? home_addr : (src_ev ? evict_addr : proc_addr);

  coh_line_table #(.NLINES(NLINES), .AW(AW), .DW(DW)) i_table (
    .clk(clk), .rst_n(rst_n), .look_addr(sel_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_st(lk_st), .lk_data(lk_data),
    .free_ok(free_ok), .free_idx(free_idx),
    .wr_en(act.set_st && go), .wr_idx(lk_hit ? lk_idx : free_idx),
    .wr_st(act.nst), .wr_addr(sel_addr),
    .wr_dat_en(act.take_home || act.take_store),
    .wr_dat(act.take_home ? home_data : proc_wdata)
  );

  assign cur_st = lk_hit ? lk_st : LN_NOTHING;

  always_comb begin
    act = '0;
    if (src_home)      act = home_action(home_cmd, cur_st);
    else if (src_ev)   act = evict_action(evict_keep, cur_st);
    else if (src_proc) act = proc_action(proc_is_store, cur_st);
  end

  // A new line is needed but every slot is held: nothing happens.
  assign need_alloc = act.set_st && !lk_hit && (act.nst != LN_NOTHING);
  assign go         = !(need_alloc && !free_ok);
  assign ev_msg     = act.send && go;
  assign ev_resp    = src_proc && act.deq;

  assign proc_deq  = ev_resp;
  assign home_deq  = home_valid;
  assign evict_deq = src_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_cmd <= '0; out_addr <= '0; out_data <= '0;
      resp_valid <= 1'b0; resp_is_ack <= 1'b0; resp_data <= '0;
    end else begin
      out_valid   <= ev_msg;
      out_cmd     <= act.cmd;
      out_addr    <= sel_addr;
      out_data    <= act.line_data ? lk_data : '0;
      resp_valid  <= ev_resp;
      resp_is_ack <= proc_is_store;
      resp_data   <= proc_is_store ? '0 : lk_data;
    end
  end

  p_home_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    home_valid |-> (home_deq && !proc_deq && !evict_deq));

  p_resp_follows_deq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    proc_deq |=> resp_valid);

  p_shreq_from_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == OM_SHREQ) |->
      $past(proc_valid && !proc_is_store && !home_valid && !evict_valid));

  p_ack_from_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_is_ack) |-> $past(proc_is_store && proc_deq));

  p_bare_msg_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_cmd == OM_SHREQ || out_cmd == OM_EXREQ || out_cmd == OM_INVREP))
      |-> (out_data == '0));

endmodule

// File: tb/test_coh_l1_ctrl.sv
`timescale 1ns/1ps
module test_coh_l1_ctrl;
  localparam int AW = 8, DW = 16;
  localparam logic [2:0] SHREP = 0, EXREP = 1, INVREQ = 2, WBREQ = 3, FLREQ = 4;
  localparam logic [2:0] SHREQ = 0, EXREQ = 1, INVREP = 2, WBREP = 3, FLREP = 4;
  localparam logic [AW-1:0] A = 8'h10, B = 8'h20;

  logic clk = 0, rst_n = 0;
  logic proc_valid = 0, proc_is_store = 0;
  logic [AW-1:0] proc_addr = '0;
  logic [DW-1:0] proc_wdata = '0;
  logic proc_deq, resp_valid, resp_is_ack;
  logic [DW-1:0] resp_data;
  logic home_valid = 0;
  logic [2:0] home_cmd = '0;
  logic [AW-1:0] home_addr = '0;
  logic [DW-1:0] home_data = '0;
  logic home_deq;
  logic evict_valid = 0, evict_keep = 0;
  logic [AW-1:0] evict_addr = '0;
  logic evict_deq, out_valid;
  logic [2:0] out_cmd;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  int n_cmp = 0, n_bad = 0;
  logic [2+AW+DW:0] exp_out[$];
  string            tag_out[$];
  logic [DW:0]      exp_rsp[$];
  string            tag_rsp[$];

  always #5 clk = ~clk;

  coh_l1_ctrl i_coh_l1_ctrl (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expo(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string req);
    exp_out.push_back({1'b0, c, a, d}); tag_out.push_back(req);
  endtask

  task automatic expr(input logic ack, input logic [DW-1:0] d, input string req);
    exp_rsp.push_back({ack, d}); tag_rsp.push_back(req);
  endtask

  // Monitor: every pulse must match the head of its expectation queue.
  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (exp_out.size() == 0) check(0, "R13 unexpected message", longint'({out_cmd, out_addr, out_data}), 0);
      else begin
        logic [2+AW+DW:0] e;
        string t;
        e = exp_out.pop_front(); t = tag_out.pop_front();
        check({1'b0, out_cmd, out_addr, out_data} == e, t,
              longint'({out_cmd, out_addr, out_data}), longint'(e));
      end
    end
    if (resp_valid) begin
      if (exp_rsp.size() == 0) check(0, "R2 unexpected response", longint'({resp_is_ack, resp_data}), 0);
      else begin
        logic [DW:0] e;
        string t;
        e = exp_rsp.pop_front(); t = tag_rsp.pop_front();
        check({resp_is_ack, resp_data} == e, t, longint'({resp_is_ack, resp_data}), longint'(e));
      end
    end
  end

  task automatic step(input bit hv, input logic [2:0] hc, input logic [AW-1:0] ha,
                      input logic [DW-1:0] hd, input bit ev, input bit ek,
                      input logic [AW-1:0] ea, input bit pv, input bit ps,
                      input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                      input bit exp_pdeq, input string req);
    @(negedge clk);
    home_valid = hv; home_cmd = hc; home_addr = ha; home_data = hd;
    evict_valid = ev; evict_keep = ek; evict_addr = ea;
    proc_valid = pv; proc_is_store = ps; proc_addr = pa; proc_wdata = pd;
    #1;
    check(proc_deq == exp_pdeq, req, proc_deq, exp_pdeq);
    if (hv) check(home_deq == 1'b1, "R11 home_deq", home_deq, 1);
    if (ev) check(evict_deq == !hv, "R11 evict_deq", evict_deq, !hv);
    @(negedge clk);
    home_valid = 0; evict_valid = 0; proc_valid = 0;
  endtask

  task automatic ld(input logic [AW-1:0] a, input bit dq, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, a, 0, dq, req);
  endtask
  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit dq, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, a, d, dq, req);
  endtask
  task automatic hm(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    step(1, c, a, d, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic ev(input bit k, input logic [AW-1:0] a, input string req);
    step(0, 0, 0, 0, 1, k, a, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && resp_valid == 0 && proc_deq == 0, "R1 reset outputs",
          {out_valid, resp_valid, proc_deq}, 0);
    rst_n = 1;
    // Load miss, stall on Pending, fill with ShRep, then hit
    expo(SHREQ, A, 0, "R1 R3 first load misses"); ld(A, 0, "R3");
    ld(A, 0, "R3 pending stalls");
    hm(SHREP, A, 16'h1111, "R6");
    expr(0, 16'h1111, "R2 load hit data"); ld(A, 1, "R2");
    // Store to Sh gives up line, then store miss
    expo(INVREP, A, 0, "R5 store on Sh"); st(A, 16'h3333, 0, "R5");
    expo(EXREQ, A, 0, "R5 store on Nothing"); st(A, 16'h3333, 0, "R5");
    hm(EXREP, A, 16'h2222, "R6");
    expr(0, 16'h2222, "R6 ExRep data"); ld(A, 1, "R6");
    expr(1, 0, "R4 store ack"); st(A, 16'h3333, 1, "R4");
    expr(0, 16'h3333, "R4 store data kept"); ld(A, 1, "R4");
    // Writeback request
    expo(WBREP, A, 16'h3333, "R8 WbRep data"); hm(WBREQ, A, 0, "R8");
    expr(0, 16'h3333, "R8 still readable"); ld(A, 1, "R8");
    hm(WBREQ, A, 0, "R8 dropped on Sh");
    expo(INVREP, A, 0, "R8 line stayed Sh"); st(A, 0, 0, "R8");
    // Stale requests on Nothing and Pending
    hm(INVREQ, A, 0, "R7"); hm(FLREQ, A, 0, "R9"); hm(WBREQ, A, 0, "R8");
    expo(SHREQ, A, 0, "R7 line still Nothing"); ld(A, 0, "R7");
    hm(INVREQ, A, 0, "R7"); hm(FLREQ, A, 0, "R9");
    ld(A, 0, "R3 still Pending");
    hm(SHREP, A, 16'h4444, "R6");
    expo(INVREP, A, 0, "R7 InvReq on Sh"); hm(INVREQ, A, 0, "R7");
    expo(SHREQ, A, 0, "R7 now Nothing"); ld(A, 0, "R7");
    hm(SHREP, A, 16'h4444, "R6");
    expo(INVREP, A, 0, "R9 flush on Sh"); hm(FLREQ, A, 0, "R9");
    expo(EXREQ, A, 0, "R9 now Nothing"); st(A, 0, 0, "R9");
    hm(EXREP, A, 16'h5555, "R6");
    expo(FLREP, A, 16'h5555, "R9 flush on Ex"); hm(FLREQ, A, 0, "R9");
    expo(SHREQ, A, 0, "R9 now Nothing"); ld(A, 0, "R9");
    // Eviction
    ev(0, A, "R10 Pending no effect"); ev(1, A, "R10 Pending no effect");
    hm(SHREP, A, 16'h6666, "R6");
    expo(INVREP, A, 0, "R10 release Sh"); ev(0, A, "R10");
    expo(SHREQ, A, 0, "R10 now Nothing"); ld(A, 0, "R10");
    hm(SHREP, A, 16'h6666, "R6");
    expo(EXREQ, B, 0, "R5"); st(B, 0, 0, "R5");
    hm(EXREP, B, 16'h0077, "R6");
    expo(WBREP, B, 16'h0077, "R10 voluntary writeback"); ev(1, B, "R10");
    expr(0, 16'h0077, "R10 kept Sh"); ld(B, 1, "R10");
    ev(1, B, "R10 writeback on Sh no effect");
    expo(INVREP, B, 0, "R10 release Sh"); ev(0, B, "R10");
    hm(EXREP, B, 16'h0088, "R6");
    expo(FLREP, B, 16'h0088, "R10 release Ex"); ev(0, B, "R10");
    // Priority: home beats processor, eviction beats processor
    expo(INVREP, A, 0, "R11 home first");
    step(1, INVREQ, A, 0, 0, 0, 0, 1, 0, A, 0, 0, "R11 proc held");
    step(0, 0, 0, 0, 1, 0, B, 1, 0, A, 0, 0, "R11 proc held by evict");
    expo(SHREQ, A, 0, "R11 A invalidated"); ld(A, 0, "R11");
    // Capacity: A pending plus three more fills all four lines
    expo(SHREQ, 8'h31, 0, "R12"); ld(8'h31, 0, "R12");
    expo(SHREQ, 8'h32, 0, "R12"); ld(8'h32, 0, "R12");
    expo(SHREQ, 8'h33, 0, "R12"); ld(8'h33, 0, "R12");
    ld(8'h34, 0, "R12 full stalls"); st(8'h34, 0, 0, "R12 full stalls");
    hm(SHREP, 8'h31, 16'h0abc, "R6");
    expo(INVREP, 8'h31, 0, "R12 free slot"); ev(0, 8'h31, "R12");
    expo(SHREQ, 8'h34, 0, "R12 uses freed slot"); ld(8'h34, 0, "R12");
    repeat (3) @(negedge clk);
    check(exp_out.size() == 0, "R13 messages missing", exp_out.size(), 0);
    check(exp_rsp.size() == 0, "R2 responses missing", exp_rsp.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule